// File: doc/BRIEF.md
# Parallel 3x3 Matrix Arithmetic Unit

This block is an arithmetic unit that works on whole 3x3 matrices. Each cycle it takes an opcode and two operands. Each operand arrives as nine element lanes side by side, so a full matrix moves in one cycle. One clock later the unit presents a nine-lane result.

It supports five operations:
- element-wise sum of two matrices;
- full matrix product;
- product of a matrix with a three-element column vector;
- scaling of a matrix by one number;
- the determinant of the first operand.

Every element of the result is computed at the same time by dedicated multiply-add lanes. The unit decodes the opcode itself. A sequencer can therefore issue a new operation on every clock, and each result comes out one cycle after its inputs.

Elements are signed two's-complement integers of parameterised width `W`. All intermediate products and sums wrap to `W` bits. No rescaling is applied.

Lane numbering follows the order row first, then column. The element at row `r`, column `c` (both counted from 0) sits on bits `[(3r+c)*W +: W]` of each bus.

Top module: `mat3_alu`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge that samples it low, every result lane becomes zero.
- R2: The result for the opcode and operands sampled at a rising edge appears on `res` after that edge and holds until the next edge. Lane (r,c) occupies bits `[(3r+c)*W +: W]`. Operations issued on back-to-back cycles each produce their own result.
- R3: Opcode 3'd1 (sum): lane (r,c) = A(r,c) + B(r,c).
- R4: Opcode 3'd2 (matrix product): lane (r,c) = A(r,0)·B(0,c) + A(r,1)·B(1,c) + A(r,2)·B(2,c).
- R5: Opcode 3'd3 (matrix-vector product): the vector is column 0 of B. Lane (r,0) = A(r,0)·B(0,0) + A(r,1)·B(1,0) + A(r,2)·B(2,0), and lanes with column 1 or 2 are zero.
- R6: Opcode 3'd4 (scale): every lane (r,c) = A(r,c)·B(0,0).
- R7: Opcode 3'd5 (determinant): lane (0,0) = A00(A11A22−A21A12) + A01(A12A20−A22A10) + A02(A10A21−A20A11), and all other lanes are zero.
- R8: All results are reduced modulo 2^W and read as two's complement. An overflowing sum or product wraps instead of saturating.
- R9: Opcodes 3'd0, 3'd6 and 3'd7 produce all-zero lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | Operation code, decoded per R3–R9 |
| src_a | input | 9*W | First operand, nine lanes |
| src_b | input | 9*W | Second operand, nine lanes (vector in column 0, scalar in lane (0,0)) |
| res | output | 9*W | Registered nine-lane result |

## Verification
The bound checker watches four things on every clock:
- the zero lanes that the matrix-vector and determinant operations must leave;
- the all-zero output for undefined opcodes;
- one-cycle arrival of an element-wise sum;
- one-cycle arrival of a scaled element.

The full matrix product, the determinant value and the wrap-around on overflow are shown only by the bench's scenarios. Its behavioural model recomputes every lane with wide integers and truncates at the end. Those scenarios include identity operands, singular matrices, extreme values and back-to-back changes of opcode.

// File: rtl/mat3_alu_pkg.sv
package mat3_alu_pkg;

    localparam int DIM   = 3;
    localparam int LANES = DIM * DIM;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SUM   = 3'd1,
        OP_MMUL  = 3'd2,
        OP_MVEC  = 3'd3,
        OP_SCALE = 3'd4,
        OP_DET   = 3'd5
    } mat3_op_e;

    function automatic int lane_of(input int row, input int col);
        return row * DIM + col;
    endfunction

endpackage

// File: rtl/mat3_dot3.sv
// Three-term dot product, reduced to W bits. Low W bits of a two's-complement
// product or sum do not depend on the discarded upper bits, so the lane is
// computed at W bits directly.
module mat3_dot3 #(
    parameter int W = 16
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] y0,
    input  logic [W-1:0] y1,
    input  logic [W-1:0] y2,
    output logic [W-1:0] dot
);

    logic [W-1:0] p0, p1, p2;

    always_comb begin
        p0  = x0 * y0;
        p1  = x1 * y1;
        p2  = x2 * y2;
        dot = p0 + p1 + p2;
    end

endmodule

// File: rtl/mat3_det.sv
// Determinant by cofactor expansion along row 0, all arithmetic modulo 2^W.
module mat3_det #(
    parameter int W = 16
) (
    input  logic [mat3_alu_pkg::LANES*W-1:0] mtx,
    output logic [W-1:0]                     det
);
    import mat3_alu_pkg::*;

    logic [W-1:0] el [LANES];
    logic [W-1:0] term [DIM];

    for (genvar n = 0; n < LANES; n++) begin : g_unpack
        assign el[n] = mtx[n*W +: W];
    end

    for (genvar k = 0; k < DIM; k++) begin : g_cof
        localparam int C1 = (k + 1) % DIM;
        localparam int C2 = (k + 2) % DIM;
        logic [W-1:0] minor_v;
        always_comb begin
            minor_v = el[lane_of(1, C1)] * el[lane_of(2, C2)]
                    - el[lane_of(2, C1)] * el[lane_of(1, C2)];
            term[k] = el[lane_of(0, k)] * minor_v;
        end
    end

    assign det = term[0] + term[1] + term[2];

endmodule

// File: rtl/mat3_alu.sv
module mat3_alu #(
    parameter int W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2:0]                        op,
    input  logic [mat3_alu_pkg::LANES*W-1:0]  src_a,
    input  logic [mat3_alu_pkg::LANES*W-1:0]  src_b,
    output logic [mat3_alu_pkg::LANES*W-1:0]  res
);
    import mat3_alu_pkg::*;

    mat3_op_e     op_e;
    logic [W-1:0] a_l   [LANES];
    logic [W-1:0] b_l   [LANES];
    logic [W-1:0] sum_l [LANES];
    logic [W-1:0] scl_l [LANES];
    logic [W-1:0] mm_l  [LANES];
    logic [W-1:0] nxt_l [LANES];
    logic [W-1:0] res_q [LANES];
    logic [W-1:0] det_v;

    assign op_e = mat3_op_e'(op);

    // Lane unpacking plus the element-wise paths.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign a_l[n]   = src_a[n*W +: W];
        assign b_l[n]   = src_b[n*W +: W];
        assign sum_l[n] = a_l[n] + b_l[n];
        assign scl_l[n] = a_l[n] * b_l[0];
        assign res[n*W +: W] = res_q[n];
    end

    // Nine row-by-column dot products. Column 0 doubles as the
    // matrix-vector result.
    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            mat3_dot3 #(.W(W)) u_dot (
                .x0  (a_l[lane_of(r, 0)]),
                .x1  (a_l[lane_of(r, 1)]),
                .x2  (a_l[lane_of(r, 2)]),
                .y0  (b_l[lane_of(0, c)]),
                .y1  (b_l[lane_of(1, c)]),
                .y2  (b_l[lane_of(2, c)]),
                .dot (mm_l[lane_of(r, c)])
            );
        end
    end

    mat3_det #(.W(W)) u_det (
        .mtx (src_a),
        .det (det_v)
    );

    // Output selection per opcode.
    always_comb begin
        for (int n = 0; n < LANES; n++) begin
            nxt_l[n] = '0;
        end
        unique case (op_e)
            OP_SUM: begin
                for (int n = 0; n < LANES; n++) nxt_l[n] = sum_l[n];
            end
            OP_MMUL: begin
                for (int n = 0; n < LANES; n++) nxt_l[n] = mm_l[n];
            end
            OP_MVEC: begin
                for (int r = 0; r < DIM; r++) nxt_l[lane_of(r, 0)] = mm_l[lane_of(r, 0)];
            end
            OP_SCALE: begin
                for (int n = 0; n < LANES; n++) nxt_l[n] = scl_l[n];
            end
            OP_DET: begin
                nxt_l[0] = det_v;
            end
            default: begin
                for (int n = 0; n < LANES; n++) nxt_l[n] = '0;
            end
        endcase
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < LANES; n++) res_q[n] <= '0;
        end else begin
            for (int n = 0; n < LANES; n++) res_q[n] <= nxt_l[n];
        end
    end

endmodule

// File: rtl/mat3_alu_chk.sv
module mat3_alu_chk #(
    parameter int W = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [2:0]                        op,
    input logic [mat3_alu_pkg::LANES*W-1:0]  src_a,
    input logic [mat3_alu_pkg::LANES*W-1:0]  src_b,
    input logic [mat3_alu_pkg::LANES*W-1:0]  res
);

    // R3
    sum_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |=> (res[8*W +: W] == W'($past(src_a[8*W +: W]) + $past(src_b[8*W +: W]))));

    // R6
    scale_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4) |=> (res[4*W +: W] == W'($past(src_a[4*W +: W]) * $past(src_b[0 +: W]))));

    // R5
    mvec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3) |=> (res[1*W +: 2*W] == '0 && res[4*W +: 2*W] == '0 && res[7*W +: 2*W] == '0));

    // R7
    det_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5) |=> (res[9*W-1:W] == '0));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0 || op == 3'd6 || op == 3'd7) |=> (res == '0));

endmodule

bind mat3_alu mat3_alu_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .src_a (src_a),
    .src_b (src_b),
    .res   (res)
);

// File: tb/mat3_alu_test.sv
module mat3_alu_test;

    localparam int W  = 16;
    localparam int BW = 9 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'd0;
    logic [BW-1:0] src_a = '0;
    logic [BW-1:0] src_b = '0;
    logic [BW-1:0] res;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int unsigned seed = 32'h1234_5678;

    longint ma [3][3];
    longint mb [3][3];

    logic [BW-1:0] exp_q;
    bit            pend = 1'b0;
    string         pend_tag;

    always #5 clk = ~clk;

    mat3_alu #(.W(W)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .src_a (src_a),
        .src_b (src_b),
        .res   (res)
    );

    function automatic longint rnd(input int lim);
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'((seed >> 8) % 32'(2 * lim + 1)) - longint'(lim);
    endfunction

    task automatic fill_rand(input int lim);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                ma[r][c] = rnd(lim);
                mb[r][c] = rnd(lim);
            end
    endtask

    // Behavioural reference: wide integer math, truncated once at the end.
    function automatic logic [BW-1:0] model(input logic [2:0] code);
        logic [BW-1:0] e = '0;
        longint v;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                v = 0;
                case (code)
                    3'd1: v = ma[r][c] + mb[r][c];
                    3'd2: for (int k = 0; k < 3; k++) v += ma[r][k] * mb[k][c];
                    3'd3: if (c == 0) for (int k = 0; k < 3; k++) v += ma[r][k] * mb[k][0];
                    3'd4: v = ma[r][c] * mb[0][0];
                    3'd5: if (r == 0 && c == 0)
                              v = ma[0][0] * (ma[1][1] * ma[2][2] - ma[2][1] * ma[1][2])
                                + ma[0][1] * (ma[1][2] * ma[2][0] - ma[2][2] * ma[1][0])
                                + ma[0][2] * (ma[1][0] * ma[2][1] - ma[2][0] * ma[1][1]);
                    default: v = 0;
                endcase
                e[(3*r+c)*W +: W] = W'(v);
            end
        return e;
    endfunction

    task automatic compare(input logic [BW-1:0] expv, input string tag);
        checks++;
        if (res !== expv) begin
            fails++;
            $display("FAIL %s: res=%h expected=%h", tag, res, expv);
        end
    endtask

    // One clock step: check the previous issue, then drive a new one.
    task automatic step(input logic [2:0] code, input string tag);
        @(negedge clk);
        if (pend) compare(exp_q, pend_tag);
        op = code;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                src_a[(3*r+c)*W +: W] = W'(ma[r][c]);
                src_b[(3*r+c)*W +: W] = W'(mb[r][c]);
            end
        exp_q    = model(code);
        pend     = 1'b1;
        pend_tag = tag;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) compare(exp_q, pend_tag);
        pend = 1'b0;
        op = 3'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R2: watchdog expired, res=%h expected=completion", res);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare('0, "R1 reset");
        rst_n = 1'b1;

        // R3: element-wise sum, several patterns
        for (int t = 0; t < 3; t++) begin
            fill_rand(200);
            step(3'd1, "R3 sum");
        end

        // R4: identity on the right returns A
        fill_rand(1000);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) mb[r][c] = (r == c) ? 1 : 0;
        step(3'd2, "R4 identity product");
        for (int t = 0; t < 3; t++) begin
            fill_rand(100);
            step(3'd2, "R4 product");
        end

        // R5: matrix-vector, junk in columns 1 and 2 of B
        for (int t = 0; t < 2; t++) begin
            fill_rand(150);
            step(3'd3, "R5 matrix-vector");
        end

        // R6: scale, negative scalar
        fill_rand(300);
        mb[0][0] = -7;
        step(3'd4, "R6 scale negative");
        fill_rand(300);
        step(3'd4, "R6 scale");

        // R7: determinants, including a singular matrix
        fill_rand(50);
        step(3'd5, "R7 det");
        ma = '{'{2, 0, 1}, '{1, 3, 2}, '{1, 1, 1}};
        step(3'd5, "R7 det singular");
        ma = '{'{4, -2, 5}, '{0, 3, -1}, '{2, 1, 6}};
        step(3'd5, "R7 det known");

        // R8: wrap-around on overflow
        fill_rand(10);
        ma[0][0] = 32767; mb[0][0] = 1;
        ma[2][2] = -32768; mb[2][2] = -1;
        step(3'd1, "R8 sum wrap");
        fill_rand(10);
        ma[0][0] = 30000; mb[0][0] = 30000;
        step(3'd4, "R8 scale wrap");
        fill_rand(32000);
        step(3'd2, "R8 product wrap");
        fill_rand(32000);
        step(3'd5, "R8 det wrap");

        // R9: undefined opcodes
        fill_rand(500);
        step(3'd0, "R9 opcode 0");
        step(3'd6, "R9 opcode 6");
        step(3'd7, "R9 opcode 7");

        // R2: back-to-back changes of opcode
        fill_rand(400);
        step(3'd4, "R2 b2b scale");
        step(3'd1, "R2 b2b sum");
        step(3'd5, "R2 b2b det");
        step(3'd3, "R2 b2b mvec");
        flush();

        // R1: reset in the middle of traffic
        fill_rand(400);
        step(3'd2, "R2 before reset");
        flush();
        fill_rand(400);
        @(negedge clk);
        op = 3'd1;
        rst_n = 1'b0;
        @(negedge clk);
        compare('0, "R1 mid-run reset");
        rst_n = 1'b1;
        op = 3'd0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule